// File: doc/BRIEF.md
# Single-Wire Debug Handshake Controller

This block sits on the target side of a single-wire debug link. It owns one open-drain pin, which appears here as a sampled pin input and two drive enables: one pulls the line low and one drives it actively high. The block does three jobs on that pin. It measures how long the host holds the line low. A long enough low pulse counts as a synchronisation request, and the block answers it with a timed response. When a command completes and the handshake is switched on, it sends a short acknowledge pulse.

A command decoder drives the strobes. `cmd_begin` marks a command as pending. `cmd_done` reports that the command has completed. `hs_on` and `hs_off` switch the handshake on and off at run time. A synchronisation request drops any pending command and reports the drop with a one-cycle status pulse. Every drive phase ends with one cycle of active-high speedup, after which the pin is released. An acknowledge pulse that collides with a host low pulse is not arbitrated.

Top module: `dbg_link_handshake`

## Requirements
- R1: After reset, `drv_low`, `drv_high`, `hs_enabled` and `abort_done` are all 0.
- R2: A `hs_on` strobe sets `hs_enabled` to 1 in the following cycle, and a `hs_off` strobe clears it. When both arrive in the same cycle, `hs_off` wins.
- R3: When `cmd_done` arrives for a pending command while `hs_enabled` is 1, `drv_low` is 1 for exactly ACK_LEN (default 16) cycles, starting in the cycle after the strobe.
- R4: Every low-drive phase is followed by exactly one cycle with `drv_high` = 1. After that cycle both enables are 0.
- R5: When `cmd_done` arrives while `hs_enabled` is 0, neither drive enable is asserted.
- R6: A host low of at least SYNC_MIN (default 128) cycles is a synchronisation request. When the host releases the line, `drv_low` is 1 for RESP_LEN (default 128) cycles, starting in the cycle after the first high sample.
- R7: A host low of SYNC_MIN-1 cycles causes no response.
- R8: A synchronisation request that arrives while a command is pending pulses `abort_done` for one cycle. That cycle is the first cycle of the response.
- R9: A `cmd_done` that arrives with no command pending is ignored: no acknowledge pulse is sent, even with the handshake on. This includes a command that was dropped by a synchronisation request.
- R10: A synchronisation request that arrives with no command pending leaves `abort_done` at 0.
- R11: `drv_low` and `drv_high` are never 1 in the same cycle.
- R12: The low-time measure restarts on every falling edge. Two low pulses, each shorter than SYNC_MIN and separated by a short high, cause no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Target clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 1 | Sampled level of the debug pin |
| cmd_begin | input | 1 | Strobe: a command is now pending |
| cmd_done | input | 1 | Strobe: the pending command has completed |
| hs_on | input | 1 | Strobe: switch the handshake on |
| hs_off | input | 1 | Strobe: switch the handshake off |
| drv_low | output | 1 | Pull the pin low |
| drv_high | output | 1 | Drive the pin high (speedup) |
| hs_enabled | output | 1 | Current handshake state |
| abort_done | output | 1 | One-cycle pulse: a pending command was dropped |

## Verification
A pending flag left set wrongly shows up in two places. It makes `abort_done` appear on a synchronisation request that had nothing to drop. It also makes a late `cmd_done` produce an acknowledge pulse. Both of these are visible within one cycle of the triggering event. A phase timer that is off by one lengthens or shortens the low drive, so the speedup cycle lands on the wrong sample of a count that is checked cycle by cycle. A low-time counter that fails to restart lets two short host pulses add up to a response. That response appears one cycle after the second release.

// File: rtl/dbg_link_handshake.sv
module dbg_link_handshake #(
  parameter int ACK_LEN  = 16,
  parameter int SYNC_MIN = 128,
  parameter int RESP_LEN = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  input  logic cmd_begin,
  input  logic cmd_done,
  input  logic hs_on,
  input  logic hs_off,
  output logic drv_low,
  output logic drv_high,
  output logic hs_enabled,
  output logic abort_done
);
  localparam int LCW  = $clog2(SYNC_MIN + 1);
  localparam int TMAX = (ACK_LEN > RESP_LEN) ? ACK_LEN : RESP_LEN;
  localparam int TW   = (TMAX > 1) ? $clog2(TMAX) : 1;

  typedef enum logic [1:0] {S_IDLE, S_ACK, S_RESP, S_SPEED} st_t;

  st_t            st;
  logic [TW-1:0]  tcnt;
  logic [LCW-1:0] low_cnt;
  logic           pin_q;
  logic           pending;
  logic           hs_en;

  wire low_full = (low_cnt == LCW'(SYNC_MIN));
  wire sync_req = (st == S_IDLE) && pin_in && !pin_q && low_full;
  wire ack_go   = (st == S_IDLE) && !sync_req && cmd_done && pending && hs_en;

  assign drv_low    = (st == S_ACK) || (st == S_RESP);
  assign drv_high   = (st == S_SPEED);
  assign hs_enabled = hs_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q   <= 1'b1;
      low_cnt <= '0;
    end else begin
      pin_q <= pin_in;
      if (drv_low || pin_in)  low_cnt <= '0;
      else if (pin_q)         low_cnt <= LCW'(1);
      else if (!low_full)     low_cnt <= low_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_en      <= 1'b0;
      pending    <= 1'b0;
      abort_done <= 1'b0;
    end else begin
      if (hs_off)     hs_en <= 1'b0;
      else if (hs_on) hs_en <= 1'b1;
      abort_done <= sync_req && pending;
      if (sync_req || cmd_done) pending <= 1'b0;
      else if (cmd_begin)       pending <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      tcnt <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          tcnt <= '0;
          if (sync_req)    st <= S_RESP;
          else if (ack_go) st <= S_ACK;
        end
        S_ACK:
          if (tcnt == TW'(ACK_LEN - 1)) begin st <= S_SPEED; tcnt <= '0; end
          else tcnt <= tcnt + 1'b1;
        S_RESP:
          if (tcnt == TW'(RESP_LEN - 1)) begin st <= S_SPEED; tcnt <= '0; end
          else tcnt <= tcnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module dbg_link_handshake_chk (
  input logic clk,
  input logic rst_n,
  input logic pin_in,
  input logic cmd_done,
  input logic drv_low,
  input logic drv_high,
  input logic abort_done
);
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_low && drv_high));
  a_r4_speedup_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_low) |-> drv_high);
  a_r4_speedup_single: assert property (@(posedge clk) disable iff (!rst_n)
    drv_high |=> !drv_high && !drv_low);
  a_r8_abort_with_resp: assert property (@(posedge clk) disable iff (!rst_n)
    abort_done |-> drv_low);
  a_r8_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
    abort_done |=> !abort_done);
  a_r3_drive_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_low) |-> ($past(cmd_done) || $past(pin_in)));
endmodule

bind dbg_link_handshake dbg_link_handshake_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cmd_done(cmd_done),
  .drv_low(drv_low), .drv_high(drv_high), .abort_done(abort_done)
);

// File: tb/dbg_link_handshake_test.sv
module dbg_link_handshake_test;
  logic clk = 0, rst_n = 0, host_low = 0;
  logic cmd_begin = 0, cmd_done = 0, hs_on = 0, hs_off = 0;
  logic drv_low, drv_high, hs_enabled, abort_done;
  logic pin_in;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  assign pin_in = !(host_low || drv_low);

  dbg_link_handshake uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cmd_begin(cmd_begin),
    .cmd_done(cmd_done), .hs_on(hs_on), .hs_off(hs_off), .drv_low(drv_low),
    .drv_high(drv_high), .hs_enabled(hs_enabled), .abort_done(abort_done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(input int which);
    case (which)
      0: cmd_begin = 1;
      1: cmd_done = 1;
      2: hs_on = 1;
      default: hs_off = 1;
    endcase
    @(negedge clk);
    cmd_begin = 0; cmd_done = 0; hs_on = 0; hs_off = 0;
  endtask

  task automatic quiet(input int n, input string req);
    bit bad = 0;
    for (int i = 0; i < n; i++) begin
      if (drv_low || drv_high) bad = 1;
      @(negedge clk);
    end
    chk(!bad, req, bad, 0);
  endtask

  task automatic drive_phase(input int len, input string req);
    int lows = 0;
    for (int i = 0; i < len; i++) begin
      if (drv_low && !drv_high) lows++;
      @(negedge clk);
    end
    chk(lows == len, req, lows, len);
    chk(drv_high && !drv_low, "R4", drv_high, 1);
    @(negedge clk);
    chk(!drv_high && !drv_low, "R4", drv_high | drv_low, 0);
  endtask

  task automatic host_pulse(input int len);
    host_low = 1;
    repeat (len) @(negedge clk);
    host_low = 0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(!drv_low && !drv_high, "R1", drv_low | drv_high, 0);
    chk(!hs_enabled && !abort_done, "R1", hs_enabled | abort_done, 0);
  endtask

  task automatic t_ack_off;
    strobe(0); strobe(1);
    quiet(24, "R5");
  endtask

  task automatic t_enable;
    strobe(2);
    chk(hs_enabled, "R2", hs_enabled, 1);
  endtask

  task automatic t_ack;
    strobe(0);
    cmd_done = 1; @(negedge clk); cmd_done = 0;
    drive_phase(16, "R3");
  endtask

  task automatic t_done_no_pending;
    strobe(1);
    quiet(24, "R9");
  endtask

  task automatic t_sync_short;
    host_pulse(127);
    quiet(140, "R7");
  endtask

  task automatic t_split;
    host_pulse(100);
    repeat (2) @(negedge clk);
    host_pulse(100);
    quiet(140, "R12");
  endtask

  task automatic t_sync_idle;
    host_pulse(128);
    chk(!abort_done, "R10", abort_done, 0);
    drive_phase(128, "R6");
  endtask

  task automatic t_sync_abort;
    strobe(0);
    host_pulse(200);
    chk(abort_done, "R8", abort_done, 1);
    @(negedge clk);
    chk(!abort_done, "R8", abort_done, 1'b0);
    drive_phase(127, "R6");
    strobe(1);
    quiet(24, "R9");
  endtask

  task automatic t_disable;
    hs_on = 1; hs_off = 1; @(negedge clk); hs_on = 0; hs_off = 0;
    chk(!hs_enabled, "R2", hs_enabled, 0);
    strobe(0); strobe(1);
    quiet(24, "R5");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ack_off();
    t_enable();
    t_ack();
    t_done_no_pending();
    t_sync_short();
    t_split();
    t_sync_idle();
    t_sync_abort();
    t_ack();
    t_disable();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule